// File: doc/BRIEF.md
# Operand Barrel Shifter

A purely combinational shift and rotate unit placed in front of the second operand input of a 32-bit arithmetic/logic unit. Each evaluation takes an operand, a shift kind, a shift amount and the current carry flag. It returns the shifted operand together with a shifter carry-out that the flag logic can capture when an instruction asks for flag updates.

Five behaviours are offered:
- logical left shift, which is also reachable under an arithmetic-left code;
- logical right shift;
- arithmetic right shift;
- rotate right;
- a single-bit rotate right through the carry flag, which treats the carry as a 33rd bit.

The amount comes from an 8-bit field, so an amount of zero and amounts at or above the operand width each have their own defined result. Instruction decode, register reads and the arithmetic unit itself sit outside this block.

Top module: `opsh_barrel`

## Requirements
- R1: When the amount is 0 and the kind code (low two bits of `kind_i`) is 0 (logical left), 1 (logical right) or 2 (arithmetic right), `result_o` equals `opnd_i` and `carry_o` equals `carry_i`.
- R2: Kind 0 with an amount n from 1 to 31 gives `opnd_i` shifted left by n with zeros entering at bit 0, and `carry_o` equal to `opnd_i` bit 32−n.
- R3: Bit 2 of `kind_i` has no effect. Code 4 is the arithmetic-left name and gives exactly the kind 0 result and carry. Codes 5, 6 and 7 behave as codes 1, 2 and 3.
- R4: Kind 1 with an amount n from 1 to 31 gives `opnd_i` shifted right by n with zeros entering at bit 31, and `carry_o` equal to `opnd_i` bit n−1.
- R5: Kind 2 with an amount n from 1 to 31 shifts right by n and refills every vacated upper bit with the original bit 31. `carry_o` is `opnd_i` bit n−1.
- R6: An amount of exactly 32 gives a result of zero for kinds 0 and 1. The carry-out is `opnd_i` bit 0 for kind 0 and `opnd_i` bit 31 for kind 1.
- R7: Amounts from 33 to 255 give a result of zero and a carry-out of 0 for kinds 0 and 1.
- R8: Kind 2 with an amount of 32 or more gives every result bit and `carry_o` equal to `opnd_i` bit 31.
- R9: Kind 3 (rotate right) with a nonzero amount n rotates by n modulo 32, and `carry_o` equals result bit 31. When n is a multiple of 32, the operand is returned unchanged and the carry-out is `opnd_i` bit 31.
- R10: Kind 3 with an amount of 0 selects the one-bit rotate through carry: `result_o` is `{carry_i, opnd_i[31:1]}` and `carry_o` is `opnd_i` bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Operand to be shifted |
| kind_i | input | 3 | Shift kind: low two bits 0 left, 1 right, 2 arithmetic right, 3 rotate; bit 2 ignored (4 = arithmetic left) |
| amt_i | input | 8 | Shift amount |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
Two functions can collide on the rotate code with an amount of zero. The pass-through rule that holds for zero amounts meets the rotate-through-carry rule that the same zero amount selects, and both are decided in the same evaluation. The bench provokes this by driving code 3 and codes 0 to 2 with amount zero back to back, once with each carry value. A collision bug shows up either as an unchanged operand under code 3, or as a carry injected into bit 31 under the other codes. Saturation at exactly 32 meets the carry picker's wrap of its index, so the amount-32 vectors are judged on both outputs together.

// File: rtl/opsh_pkg.sv
package opsh_pkg;

   typedef enum logic [1:0] {
      SH_LL = 2'd0,
      SH_LR = 2'd1,
      SH_AR = 2'd2,
      SH_RR = 2'd3
   } sh_kind_e;

   localparam int KIND_CODE_W = 3;

endpackage

// File: rtl/opsh_amt_decode.sv
module opsh_amt_decode #(
   parameter int W     = 32,
   parameter int AMT_W = 8
) (
   input  logic [AMT_W-1:0]      amt_i,
   output logic                  amt_zero_o,
   output logic                  amt_full_o,
   output logic                  amt_over_o,
   output logic [$clog2(W)-1:0]  amt_lo_o
);
   localparam int LG = $clog2(W);
   localparam logic [AMT_W-1:0] W_AMT = AMT_W'(W);

   if (AMT_W <= LG) begin : g_bad_amt
      $error("opsh_amt_decode: AMT_W must be able to hold the width");
   end

   assign amt_zero_o = (amt_i == '0);
   assign amt_full_o = (amt_i == W_AMT);
   assign amt_over_o = (amt_i >  W_AMT);
   assign amt_lo_o   = amt_i[LG-1:0];
endmodule

// File: rtl/opsh_stage_chain.sv
module opsh_stage_chain #(
   parameter int W = 32
) (
   input  logic [W-1:0]          din_i,
   input  logic [$clog2(W)-1:0]  shamt_i,
   input  logic                  fill_i,
   input  logic                  wrap_i,
   output logic [W-1:0]          dout_o
);
   localparam int LG = $clog2(W);

   logic [W-1:0] stg [LG+1];

   assign stg[0] = din_i;

   for (genvar k = 0; k < LG; k++) begin : g_stage
      localparam int S = 1 << k;
      logic [S-1:0] top_in;
      assign top_in     = wrap_i ? stg[k][S-1:0] : {S{fill_i}};
      assign stg[k+1]   = shamt_i[k] ? {top_in, stg[k][W-1:S]} : stg[k];
   end

   assign dout_o = stg[LG];
endmodule

// File: rtl/opsh_carry_pick.sv
module opsh_carry_pick #(
   parameter int W = 32
) (
   input  logic [W-1:0]          din_i,
   input  logic [$clog2(W)-1:0]  shamt_i,
   input  logic                  left_i,
   output logic                  cbit_o
);
   localparam int LG = $clog2(W);
   localparam logic [LG-1:0] ONE = LG'(1);

   logic [LG-1:0] idx;

   always_comb begin
      if (left_i) idx = '0 - shamt_i;
      else        idx = shamt_i - ONE;
   end

   assign cbit_o = din_i[idx];
endmodule

// File: rtl/opsh_barrel.sv
module opsh_barrel #(
   parameter int W     = 32,
   parameter int AMT_W = 8
) (
   input  logic [W-1:0]                     opnd_i,
   input  logic [opsh_pkg::KIND_CODE_W-1:0] kind_i,
   input  logic [AMT_W-1:0]                 amt_i,
   input  logic                             carry_i,
   output logic [W-1:0]                     result_o,
   output logic                             carry_o
);
   import opsh_pkg::*;

   localparam int LG = $clog2(W);
   localparam logic [AMT_W-1:0] W_AMT = AMT_W'(W);

   if (W < 2 || (1 << LG) != W) begin : g_bad_width
      $error("opsh_barrel: W must be a power of two of at least 2");
   end

   sh_kind_e      kind;
   logic          unused_kind_hi;
   logic          amt_zero, amt_full, amt_over;
   logic [LG-1:0] amt_lo;
   logic [W-1:0]  opnd_rev, left_rev, left_res, right_res;
   logic          msb, right_fill, cpick;

   assign kind           = sh_kind_e'(kind_i[1:0]);
   assign unused_kind_hi = kind_i[2];
   assign msb            = opnd_i[W-1];
   assign right_fill     = (kind == SH_AR) && msb;

   opsh_amt_decode #(.W(W), .AMT_W(AMT_W)) dec_i (
      .amt_i      (amt_i),
      .amt_zero_o (amt_zero),
      .amt_full_o (amt_full),
      .amt_over_o (amt_over),
      .amt_lo_o   (amt_lo)
   );

   for (genvar i = 0; i < W; i++) begin : g_rev
      assign opnd_rev[i] = opnd_i[W-1-i];
      assign left_res[i] = left_rev[W-1-i];
   end

   opsh_stage_chain #(.W(W)) left_chain_i (
      .din_i   (opnd_rev),
      .shamt_i (amt_lo),
      .fill_i  (1'b0),
      .wrap_i  (1'b0),
      .dout_o  (left_rev)
   );

   opsh_stage_chain #(.W(W)) right_chain_i (
      .din_i   (opnd_i),
      .shamt_i (amt_lo),
      .fill_i  (right_fill),
      .wrap_i  (kind == SH_RR),
      .dout_o  (right_res)
   );

   opsh_carry_pick #(.W(W)) carry_pick_i (
      .din_i   (opnd_i),
      .shamt_i (amt_lo),
      .left_i  (kind == SH_LL),
      .cbit_o  (cpick)
   );

   always_comb begin
      result_o = opnd_i;
      carry_o  = carry_i;
      case (kind)
         SH_LL, SH_LR: begin
            if (amt_zero) begin
               result_o = opnd_i;
               carry_o  = carry_i;
            end else if (amt_over) begin
               result_o = '0;
               carry_o  = 1'b0;
            end else if (amt_full) begin
               result_o = '0;
               carry_o  = cpick;
            end else begin
               result_o = (kind == SH_LL) ? left_res : right_res;
               carry_o  = cpick;
            end
         end
         SH_AR: begin
            if (amt_zero) begin
               result_o = opnd_i;
               carry_o  = carry_i;
            end else if (amt_full || amt_over) begin
               result_o = {W{msb}};
               carry_o  = msb;
            end else begin
               result_o = right_res;
               carry_o  = cpick;
            end
         end
         SH_RR: begin
            if (amt_zero) begin
               result_o = {carry_i, opnd_i[W-1:1]};
               carry_o  = opnd_i[0];
            end else begin
               result_o = right_res;
               carry_o  = cpick;
            end
         end
         default: begin
            result_o = opnd_i;
            carry_o  = carry_i;
         end
      endcase
   end

   always_comb begin
      if (amt_i == '0 && kind != SH_RR) begin
         assert_zero_pass_R1: assert (result_o == opnd_i && carry_o == carry_i)
            else $error("zero amount did not pass operand and carry");
      end
      if (kind == SH_LL && amt_i != '0 && amt_i < W_AMT) begin
         assert_left_zero_fill_R2: assert (result_o[0] == 1'b0)
            else $error("left shift left a one in bit 0");
      end
      if (kind == SH_AR && amt_i != '0) begin
         assert_arith_sign_R5: assert (result_o[W-1] == opnd_i[W-1])
            else $error("arithmetic right lost the sign bit");
      end
      if ((kind == SH_LL || kind == SH_LR) && amt_i > W_AMT) begin
         assert_logic_over_R7: assert (result_o == '0 && carry_o == 1'b0)
            else $error("logical shift past width not cleared");
      end
      if (kind == SH_AR && amt_i >= W_AMT) begin
         assert_arith_sat_R8: assert (result_o == {W{opnd_i[W-1]}} && carry_o == opnd_i[W-1])
            else $error("arithmetic saturation wrong");
      end
      if (kind == SH_RR && amt_i != '0) begin
         assert_rot_carry_R9: assert (carry_o == result_o[W-1])
            else $error("rotate carry differs from result top bit");
      end
      if (kind == SH_RR && amt_i == '0) begin
         assert_rrx_R10: assert (result_o[W-1] == carry_i && carry_o == opnd_i[0])
            else $error("rotate through carry wrong");
      end
   end
endmodule

// File: tb/opsh_barrel_tb_top.sv
module opsh_barrel_tb_top;

   typedef struct {
      logic [31:0] res;
      logic        cy;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] opnd = '0;
   logic [2:0]  kind = '0;
   logic [7:0]  amt = '0;
   logic        cin = 1'b0;
   logic [31:0] res;
   logic        cout;

   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 1'b0;
   exp_t sb_q[$];

   always #2.5 clk = ~clk;

   opsh_barrel dut_i (
      .opnd_i   (opnd),
      .kind_i   (kind),
      .amt_i    (amt),
      .carry_i  (cin),
      .result_o (res),
      .carry_o  (cout)
   );

   function automatic logic [32:0] model(input logic [31:0] x, input logic [1:0] k,
                                         input int n, input logic c);
      logic [63:0]        t;
      logic signed [63:0] ts;
      logic [31:0]        r;
      case (k)
         2'd0: begin
            if (n == 0) return {c, x};
            if (n > 32) return 33'd0;
            t = {32'd0, x} << n;
            return {t[32], t[31:0]};
         end
         2'd1: begin
            if (n == 0) return {c, x};
            if (n > 32) return 33'd0;
            t = {x, 32'd0} >> n;
            return {t[31], t[63:32]};
         end
         2'd2: begin
            if (n == 0) return {c, x};
            if (n >= 32) return {x[31], {32{x[31]}}};
            ts = $signed({x, 32'd0}) >>> n;
            return {ts[31], ts[63:32]};
         end
         default: begin
            if (n == 0) return {x[0], c, x[31:1]};
            if (n % 32 == 0) return {x[31], x};
            t = {x, x} >> (n % 32);
            r = t[31:0];
            return {r[31], r};
         end
      endcase
   endfunction

   task automatic apply(input logic [31:0] x, input logic [2:0] k, input int n,
                        input logic c, input string tag);
      logic [32:0] e;
      exp_t it;
      @(posedge clk);
      #1;
      opnd = x;
      kind = k;
      amt  = 8'(n);
      cin  = c;
      e = model(x, k[1:0], n, c);
      it.res = e[31:0];
      it.cy  = e[32];
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   always @(negedge clk) begin
      if (rst_n && sb_q.size() > 0) begin
         exp_t it;
         it = sb_q.pop_front();
         n_checks++;
         if (res !== it.res || cout !== it.cy) begin
            n_errors++;
            $display("FAIL %s: got res=%h c=%b expected res=%h c=%b (opnd=%h kind=%0d amt=%0d cin=%b)",
                     it.tag, res, cout, it.res, it.cy, opnd, kind, amt, cin);
         end
      end
   end

   function automatic string sweep_tag(input logic [1:0] k, input int n);
      if (n == 0) return (k == 2'd3) ? "R10 sweep" : "R1 sweep";
      case (k)
         2'd0: return (n < 32) ? "R2 sweep" : (n == 32) ? "R6 sweep" : "R7 sweep";
         2'd1: return (n < 32) ? "R4 sweep" : (n == 32) ? "R6 sweep" : "R7 sweep";
         2'd2: return (n < 32) ? "R5 sweep" : "R8 sweep";
         default: return "R9 sweep";
      endcase
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      apply(32'h0, 3'd0, 0, 1'b0, "R1 idle all-zero state");

      // R1 and R10: zero amount, pass-through against rotate-through-carry
      for (int c = 0; c < 2; c++) begin
         apply(32'h8000_0001, 3'd0, 0, c[0], "R1 LSL amount 0");
         apply(32'h8000_0001, 3'd3, 0, c[0], "R10 ROR amount 0");
         apply(32'h8000_0001, 3'd1, 0, c[0], "R1 LSR amount 0");
         apply(32'h8000_0001, 3'd2, 0, c[0], "R1 ASR amount 0");
         apply(32'h7FFF_FFFE, 3'd3, 0, c[0], "R10 ROR amount 0 even");
      end

      apply(32'h8000_0001, 3'd0, 1,  1'b0, "R2 LSL 1");
      apply(32'h1234_5678, 3'd0, 4,  1'b1, "R2 LSL 4");
      apply(32'h0000_0001, 3'd0, 31, 1'b0, "R2 LSL 31");
      apply(32'h0000_0002, 3'd0, 31, 1'b0, "R2 LSL 31 carry");

      apply(32'hF0F0_1234, 3'd4, 5, 1'b0, "R3 ASL alias code 4");
      apply(32'hF0F0_1234, 3'd5, 5, 1'b1, "R3 code 5 as LSR");
      apply(32'hF0F0_1234, 3'd6, 5, 1'b0, "R3 code 6 as ASR");
      apply(32'hF0F0_1234, 3'd7, 5, 1'b0, "R3 code 7 as ROR");
      apply(32'hF0F0_1234, 3'd7, 0, 1'b1, "R3 code 7 amount 0");

      apply(32'h8000_0001, 3'd1, 1,  1'b0, "R4 LSR 1");
      apply(32'hABCD_8000, 3'd1, 16, 1'b0, "R4 LSR 16");
      apply(32'h8000_0000, 3'd1, 31, 1'b0, "R4 LSR 31");

      apply(32'h8000_0001, 3'd2, 1,  1'b0, "R5 ASR 1 negative");
      apply(32'h7000_0040, 3'd2, 7,  1'b1, "R5 ASR 7 positive");
      apply(32'hC000_0000, 3'd2, 31, 1'b0, "R5 ASR 31");

      apply(32'h0000_0001, 3'd0, 32, 1'b0, "R6 LSL 32");
      apply(32'hFFFF_FFFE, 3'd0, 32, 1'b1, "R6 LSL 32 bit0 clear");
      apply(32'h8000_0000, 3'd1, 32, 1'b0, "R6 LSR 32");
      apply(32'h7FFF_FFFF, 3'd1, 32, 1'b1, "R6 LSR 32 bit31 clear");

      apply(32'hFFFF_FFFF, 3'd0, 33,  1'b1, "R7 LSL 33");
      apply(32'hFFFF_FFFF, 3'd1, 255, 1'b1, "R7 LSR 255");

      apply(32'h8000_0000, 3'd2, 32,  1'b0, "R8 ASR 32 negative");
      apply(32'h7FFF_FFFF, 3'd2, 200, 1'b1, "R8 ASR 200 positive");

      apply(32'h0000_0001, 3'd3, 1,   1'b0, "R9 ROR 1");
      apply(32'h1234_5678, 3'd3, 8,   1'b0, "R9 ROR 8");
      apply(32'h8000_0001, 3'd3, 31,  1'b0, "R9 ROR 31");
      apply(32'h8000_0001, 3'd3, 32,  1'b0, "R9 ROR 32");
      apply(32'h0000_0001, 3'd3, 64,  1'b1, "R9 ROR 64");
      apply(32'hDEAD_BEEF, 3'd3, 37,  1'b0, "R9 ROR 37");

      for (int i = 0; i < 400; i++) begin
         logic [31:0] x;
         logic [1:0]  k;
         int          n;
         x = 32'(i) * 32'h9E37_79B9 ^ 32'h5A5A_0F0F;
         k = 2'(i);
         n = (i * 7) % 70;
         apply(x, {1'b0, k}, n, x[3], sweep_tag(k, n));
      end

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: got no end expected end of stimulus");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule